// File: doc/BRIEF.md
# Layout-Aware Character Address Counter

This block keeps the 7-bit address that a character display controller uses for every data transfer. The address targets either the display character memory or the user pattern memory. A set-address command loads it and chooses the target. Each completed data read or write then moves it by one step. The step goes up or down according to a stored direction bit.

While the counter targets display memory, the step follows the configured screen layout. The layout is one wide line of 80 addresses, two lines with an address gap between them, or one short line used in the reduced multiplex mode. While it targets pattern memory, the step simply wraps modulo 128.

The block also produces the cursor-visible qualifier. This signal drops whenever the address points into pattern memory. The target is held in a two-state machine with the states TGT_DISPLAY and TGT_PATTERN. The transition to TGT_DISPLAY is taken on a display load. The transition to TGT_PATTERN is taken on a pattern load that has no display load in the same cycle. With no load, the machine stays in its current state.

Top module: `disp_addr_counter`

## Requirements
- R1: After reset the address is 0x00, the target is display memory (`pattern_sel` = 0) and the direction is up (`dir_up` = 1).
- R2: An `access` strobe changes the address by exactly one, up when `dir_up` = 1 and down when `dir_up` = 0. A cycle with no strobe and no load leaves the address unchanged.
- R3: With `layout` = 2'b00 (one line of 80), or with the unused code 2'b11, an up step from 0x4F gives 0x00 and a down step from 0x00 gives 0x4F.
- R4: With `layout` = 2'b01 (two lines), an up step goes from 0x27 to 0x40 and from 0x67 to 0x00.
- R5: With `layout` = 2'b01, a down step goes from 0x00 to 0x67 and from 0x40 to 0x27.
- R6: With `layout` = 2'b10 (short line), an up step goes from 0x27 to 0x00 and a down step goes from 0x00 to 0x27.
- R7: A pattern load (`load_pat`) replaces address bits 5..0 with `load_val[5:0]`, keeps bit 6 and selects pattern memory.
- R8: A display load (`load_disp`) writes all 7 bits of `load_val` and selects display memory.
- R9: While pattern memory is selected, steps wrap modulo 128 and ignore `layout`; an up step from 0x3F reaches 0x40.
- R10: `cursor_show` equals `cursor_en` while display memory is selected and is 0 while pattern memory is selected.
- R11: A load in the same cycle as `access` takes precedence over the step. A display load in the same cycle as a pattern load takes precedence over the pattern load.
- R12: A direction write (`dir_wr` with `dir_up_in`) takes effect from the next cycle. A step in the same cycle as the write uses the old direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| layout | input | 2 | Screen layout: 00 wide line, 01 two lines, 10 short line |
| dir_wr | input | 1 | Entry-direction write strobe |
| dir_up_in | input | 1 | New direction, 1 = up |
| load_disp | input | 1 | Set display address command |
| load_pat | input | 1 | Set pattern address command |
| load_val | input | 7 | Address value carried by the load commands |
| access | input | 1 | One data read or write completed |
| cursor_en | input | 1 | Cursor enabled by display control |
| addr | output | 7 | Current address |
| pattern_sel | output | 1 | 1 when the address targets pattern memory |
| dir_up | output | 1 | Current step direction |
| cursor_show | output | 1 | Cursor may be drawn |

## Verification
Three kinds of update can arrive in the same cycle: a load, a step and a direction write. The bench drives an `access` strobe together with a display load, and together with a pattern load. It expects the loaded value in both cases, with no step applied. It also drives both loads at once and expects the display value and the display target. Finally, it pairs a step with a direction change and expects the step to move in the old direction and the following step to move in the new one.

// File: rtl/dac_pkg.sv
`timescale 1ns/1ps
package dac_pkg;
    typedef enum logic [1:0] {
        LAY_WIDE  = 2'b00,
        LAY_TWO   = 2'b01,
        LAY_SHORT = 2'b10
    } layout_e;

    typedef enum logic {
        TGT_DISPLAY = 1'b0,
        TGT_PATTERN = 1'b1
    } target_e;
endpackage

// File: rtl/dac_dir_reg.sv
`timescale 1ns/1ps
module dac_dir_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_wr,
    input  logic dir_up_in,
    output logic dir_up
);
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_up <= 1'b1;
        else if (dir_wr) dir_up <= dir_up_in;
    end

    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R12: the direction changes only through a write
    assert_dir_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !dir_wr |=> $stable(dir_up));
endmodule

// File: rtl/dac_step.sv
`timescale 1ns/1ps
module dac_step #(
    parameter int AW         = 7,
    parameter int WIDE_SPAN  = 80,
    parameter int LINE_SPAN  = 40,
    parameter int LINE2_BASE = 64,
    parameter int SHORT_SPAN = 40
) (
    input  logic [AW-1:0] cur,
    input  logic [1:0]    layout,
    input  logic          pattern,
    input  logic          up,
    output logic [AW-1:0] nxt
);
    import dac_pkg::*;

    localparam logic [AW-1:0] ONE        = AW'(1);
    localparam logic [AW-1:0] ZERO       = '0;
    localparam logic [AW-1:0] WIDE_LAST  = AW'(WIDE_SPAN - 1);
    localparam logic [AW-1:0] L1_LAST    = AW'(LINE_SPAN - 1);
    localparam logic [AW-1:0] L2_FIRST   = AW'(LINE2_BASE);
    localparam logic [AW-1:0] L2_LAST    = AW'(LINE2_BASE + LINE_SPAN - 1);
    localparam logic [AW-1:0] SHORT_LAST = AW'(SHORT_SPAN - 1);

    always_comb begin
        nxt = up ? cur + ONE : cur - ONE;
        if (!pattern) begin
            unique case (layout)
                LAY_TWO: begin
                    if (up) begin
                        if (cur == L1_LAST)      nxt = L2_FIRST;
                        else if (cur == L2_LAST) nxt = ZERO;
                    end else begin
                        if (cur == ZERO)          nxt = L2_LAST;
                        else if (cur == L2_FIRST) nxt = L1_LAST;
                    end
                end
                LAY_SHORT: begin
                    if (up && cur == SHORT_LAST) nxt = ZERO;
                    else if (!up && cur == ZERO) nxt = SHORT_LAST;
                end
                default: begin
                    if (up && cur == WIDE_LAST)  nxt = ZERO;
                    else if (!up && cur == ZERO) nxt = WIDE_LAST;
                end
            endcase
        end
    end
endmodule

// File: rtl/disp_addr_counter.sv
`timescale 1ns/1ps
module disp_addr_counter #(
    parameter int AW         = 7,
    parameter int WIDE_SPAN  = 80,
    parameter int LINE_SPAN  = 40,
    parameter int LINE2_BASE = 64,
    parameter int SHORT_SPAN = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    layout,
    input  logic          dir_wr,
    input  logic          dir_up_in,
    input  logic          load_disp,
    input  logic          load_pat,
    input  logic [AW-1:0] load_val,
    input  logic          access,
    input  logic          cursor_en,
    output logic [AW-1:0] addr,
    output logic          pattern_sel,
    output logic          dir_up,
    output logic          cursor_show
);
    import dac_pkg::*;

    localparam logic [AW-1:0] ONE     = AW'(1);
    localparam logic [AW-1:0] L1_LAST = AW'(LINE_SPAN - 1);
    localparam logic [AW-1:0] L2_LO   = AW'(LINE2_BASE);
    localparam logic [AW-1:0] L2_HI   = AW'(LINE2_BASE + LINE_SPAN - 1);

    target_e       tgt_q, tgt_d;
    logic [AW-1:0] step_nxt;

    dac_dir_reg u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_wr   (dir_wr),
        .dir_up_in(dir_up_in),
        .dir_up   (dir_up)
    );

    dac_step #(
        .AW        (AW),
        .WIDE_SPAN (WIDE_SPAN),
        .LINE_SPAN (LINE_SPAN),
        .LINE2_BASE(LINE2_BASE),
        .SHORT_SPAN(SHORT_SPAN)
    ) u_step (
        .cur    (addr),
        .layout (layout),
        .pattern(tgt_q == TGT_PATTERN),
        .up     (dir_up),
        .nxt    (step_nxt)
    );

    // target state machine: next state
    always_comb begin
        tgt_d = tgt_q;
        unique case (tgt_q)
            TGT_DISPLAY: if (!load_disp && load_pat) tgt_d = TGT_PATTERN;
            TGT_PATTERN: if (load_disp)              tgt_d = TGT_DISPLAY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) tgt_q <= TGT_DISPLAY;
        else        tgt_q <= tgt_d;
    end

    // address register: loads win over the step
    always_ff @(posedge clk) begin
        if (!rst_n)         addr <= '0;
        else if (load_disp) addr <= load_val;
        else if (load_pat)  addr <= {addr[AW-1], load_val[AW-2:0]};
        else if (access)    addr <= step_nxt;
    end

    // outputs
    always_comb begin
        unique case (tgt_q)
            TGT_DISPLAY: begin pattern_sel = 1'b0; cursor_show = cursor_en; end
            TGT_PATTERN: begin pattern_sel = 1'b1; cursor_show = 1'b0;      end
        endcase
    end

    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    logic in_two;
    assign in_two = (addr <= L1_LAST) || (addr >= L2_LO && addr <= L2_HI);

    assert_disp_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed && load_disp |=> addr == $past(load_val) && !pattern_sel);

    assert_pat_keep6_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed && load_pat && !load_disp |=> addr[AW-1] == $past(addr[AW-1]) && pattern_sel);

    assert_cursor_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        armed && load_pat && !load_disp |=> !cursor_show);

    assert_pat_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed && access && !load_disp && !load_pat && pattern_sel
        |=> addr == ($past(dir_up) ? $past(addr) + ONE : $past(addr) - ONE));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !access && !load_disp && !load_pat |=> $stable(addr));

    assert_two_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed && access && !load_disp && !load_pat && !pattern_sel
        && layout == LAY_TWO && in_two |=> in_two);
endmodule

// File: tb/test_disp_addr_counter.sv
`timescale 1ns/1ps
module test_disp_addr_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] layout = 2'b00;
    logic       dir_wr = 1'b0, dir_up_in = 1'b1;
    logic       load_disp = 1'b0, load_pat = 1'b0, access = 1'b0;
    logic [6:0] load_val = '0;
    logic       cursor_en = 1'b1;
    logic [6:0] addr;
    logic       pattern_sel, dir_up, cursor_show;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk; // 50 MHz

    disp_addr_counter i_disp_addr_counter (
        .clk(clk), .rst_n(rst_n), .layout(layout), .dir_wr(dir_wr),
        .dir_up_in(dir_up_in), .load_disp(load_disp), .load_pat(load_pat),
        .load_val(load_val), .access(access), .cursor_en(cursor_en),
        .addr(addr), .pattern_sel(pattern_sel), .dir_up(dir_up),
        .cursor_show(cursor_show)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one cycle of stimulus, applied at a falling edge and removed at the next
    task automatic pulse(input logic ld_d, input logic ld_p, input logic [6:0] val,
                         input logic acc, input logic dw, input logic dup);
        @(negedge clk);
        load_disp = ld_d; load_pat = ld_p; load_val = val;
        access = acc; dir_wr = dw; dir_up_in = dup;
        @(negedge clk);
        load_disp = 1'b0; load_pat = 1'b0; access = 1'b0; dir_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 addr", addr, 0);
        check("R1 target", pattern_sel, 0);
        check("R1 dir", dir_up, 1);
        check("R10 cursor on display", cursor_show, 1);
    endtask

    task automatic t_idle_step();
        repeat (3) @(negedge clk);
        check("R2 idle hold", addr, 0);
        pulse(0, 0, 0, 1, 0, 1);
        check("R2 step up", addr, 1);
    endtask

    task automatic t_wide();
        layout = 2'b00;
        pulse(1, 0, 7'h4E, 0, 0, 1); check("R8 load", addr, 7'h4E);
        pulse(0, 0, 0, 1, 0, 1);     check("R2 up", addr, 7'h4F);
        pulse(0, 0, 0, 1, 0, 1);     check("R3 up wrap", addr, 7'h00);
        pulse(0, 0, 0, 0, 1, 0);     check("R12 dir written", dir_up, 0);
        check("R2 dir write alone", addr, 7'h00);
        pulse(0, 0, 0, 1, 0, 0);     check("R3 down wrap", addr, 7'h4F);
        pulse(0, 0, 0, 1, 0, 0);     check("R2 down", addr, 7'h4E);
        layout = 2'b11;
        pulse(0, 0, 0, 0, 1, 1);
        pulse(1, 0, 7'h4F, 0, 0, 1);
        pulse(0, 0, 0, 1, 0, 1);     check("R3 code 11 wrap", addr, 7'h00);
    endtask

    task automatic t_two();
        layout = 2'b01;
        pulse(1, 0, 7'h26, 0, 0, 1);
        pulse(0, 0, 0, 1, 0, 1);     check("R4 to 27", addr, 7'h27);
        pulse(0, 0, 0, 1, 0, 1);     check("R4 27->40", addr, 7'h40);
        pulse(1, 0, 7'h67, 0, 0, 1);
        pulse(0, 0, 0, 1, 0, 1);     check("R4 67->00", addr, 7'h00);
        pulse(0, 0, 0, 0, 1, 0);
        pulse(0, 0, 0, 1, 0, 0);     check("R5 00->67", addr, 7'h67);
        pulse(1, 0, 7'h40, 0, 0, 0);
        pulse(0, 0, 0, 1, 0, 0);     check("R5 40->27", addr, 7'h27);
    endtask

    task automatic t_short();
        layout = 2'b10;
        pulse(1, 0, 7'h00, 0, 0, 0);
        pulse(0, 0, 0, 1, 0, 0);     check("R6 down wrap", addr, 7'h27);
        pulse(0, 0, 0, 0, 1, 1);
        pulse(0, 0, 0, 1, 0, 1);     check("R6 up wrap", addr, 7'h00);
    endtask

    task automatic t_pattern();
        layout = 2'b01;
        pulse(1, 0, 7'h45, 0, 0, 1);
        pulse(0, 1, 7'h3F, 0, 0, 1);
        check("R7 keep bit6", addr, 7'h7F);
        check("R7 target", pattern_sel, 1);
        check("R10 cursor off", cursor_show, 0);
        pulse(0, 0, 0, 1, 0, 1);     check("R9 up mod128", addr, 7'h00);
        pulse(0, 0, 0, 0, 1, 0);
        pulse(0, 0, 0, 1, 0, 0);     check("R9 down mod128", addr, 7'h7F);
        pulse(1, 0, 7'h00, 0, 0, 0);
        pulse(0, 1, 7'h3F, 0, 0, 0); check("R7 bit6 clear kept", addr, 7'h3F);
        pulse(0, 0, 0, 0, 1, 1);
        pulse(0, 0, 0, 1, 0, 1);     check("R9 3F->40", addr, 7'h40);
        pulse(1, 0, 7'h10, 0, 0, 1);
        check("R8 target", pattern_sel, 0);
        check("R10 cursor back", cursor_show, 1);
    endtask

    task automatic t_collide();
        layout = 2'b01;
        pulse(1, 0, 7'h20, 1, 0, 1); check("R11 disp load over step", addr, 7'h20);
        pulse(1, 1, 7'h05, 0, 0, 1);
        check("R11 disp over pat addr", addr, 7'h05);
        check("R11 disp over pat target", pattern_sel, 0);
        pulse(0, 1, 7'h11, 1, 0, 1); check("R11 pat load over step", addr, 7'h11);
        check("R11 pat target", pattern_sel, 1);
    endtask

    task automatic t_dir_same();
        layout = 2'b00;
        pulse(1, 0, 7'h05, 0, 0, 1);
        pulse(0, 0, 0, 1, 1, 0);     check("R12 old direction used", addr, 7'h06);
        check("R12 new direction stored", dir_up, 0);
        pulse(0, 0, 0, 1, 0, 0);     check("R12 new direction used", addr, 7'h05);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_step();
        t_wide();
        t_two();
        t_short();
        t_pattern();
        t_collide();
        t_dir_same();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule